// File: doc/BRIEF.md
# Converter Output Formatter with Selectable Clock Phase

This block sits between the quantizer of a 12-bit sampling converter and its output pads. It receives a signed sample wider than 12 bits once per sample period, clips it to the 12-bit range and raises an overflow flag when clipping happens. It codes the clipped value as offset binary or as two's complement and delays the word and its flag together through a fixed pipeline. It also makes an output clock at the sample rate for latching that data. The clock can be shifted in eighth-of-period steps.

The block runs from a fast clock at eight times the sample rate. An internal slot counter divides each sample period into eight fast cycles. The edge that ends the eighth cycle is the sample boundary. At every boundary the block captures the sample and all of its mode inputs: coding select, phase field, clock invert, stabilizer enable and double-data-rate enable. Between boundaries it ignores those inputs, so a mode change always lands on a period edge.

In full-rate mode the whole word is presented for a full period. In double-data-rate mode the word is split into two six-bit halves, one for each half of the period, so that one output-clock edge marks each half.

Top module: `adcfmt_top`

## Requirements
- R1: The overflow output is 1 for a captured sample above +2047 or below -2048, and 0 for any sample from -2048 to +2047 inclusive.
- R2: A sample above +2047 is coded as 0xFFF in offset binary or 0x7FF in two's complement. A sample below -2048 is coded as 0x000 in offset binary or 0x800 in two's complement.
- R3: With `fmt_twos`=0 an in-range value v is coded as v+2048. So 0 gives 0x800, -1 gives 0x7FF, +2047 gives 0xFFF and -2048 gives 0x000.
- R4: With `fmt_twos`=1 an in-range value v is coded as its low 12 bits in two's complement. So 0 gives 0x000, -1 gives 0xFFF, +2047 gives 0x7FF and -2048 gives 0x800.
- R5: The coded word and its overflow flag captured at boundary n are both driven starting at boundary n+PIPE_LAT-1 (boundary n+4 at the default of 5). In full-rate mode they stay unchanged for the whole period that follows.
- R6: The output clock has a period of eight fast cycles and a 50% duty cycle. With zero shift it goes low at each boundary edge, which is the edge at which the data changes, and goes high four fast cycles later.
- R7: With `dcs_en`=1 and `clk_inv`=0, `ph_sel` values 0, 1, 2 and 3 delay both clock edges by 0, 1, 2 and 3 fast cycles (0°, 45°, 90°, 135°).
- R8: `clk_inv`=1 adds four fast cycles (180°) to whatever shift `ph_sel` gives. All eight shifts from 0° to 315° can be reached.
- R9: With `dcs_en`=0 the value of `ph_sel` has no effect; only `clk_inv` moves the clock.
- R10: With `ddr_en`=1 the word is sent in two halves on `dout[5:0]`, with `dout[11:6]` held at 0. Bits 5:0 are sent in fast cycles 0-3 after a boundary, with `ovf` at 0. Bits 11:6 are sent in cycles 4-7, with `ovf` equal to the flag.
- R11: Changes on the sample and mode inputs between boundaries have no effect on any output until the next boundary captures them.
- R12: While `rst_n` is low, `dout`, `ovf` and `clk_out` are 0. The first boundary is the tenth rising edge after `rst_n` rises, and the clock follows zero shift until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, eight cycles per sample |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_in | input | IN_W (14) | Signed quantizer sample |
| fmt_twos | input | 1 | 1 selects two's complement, 0 selects offset binary |
| ph_sel | input | 2 | Clock shift in 45° steps |
| clk_inv | input | 1 | Adds 180° to the clock shift |
| dcs_en | input | 1 | Stabilizer enable; the phase field works only when set |
| ddr_en | input | 1 | Selects double-data-rate half-word output |
| dout | output | DW (12) | Output data word or half-word |
| ovf | output | 1 | Overflow flag aligned with its data |
| clk_out | output | 1 | Phase-selectable output clock |

## Verification
Samples are sent at and around the two clip points (+2047/+2048, -2048/-2049), at zero and minus one, at the input extremes and at pseudo-random values, in both codings. These patterns separate a wrong clip threshold, a flipped sign bit and a flag that arrives one period away from its data. The clock is swept through all eight invert and phase combinations with the stabilizer on, and through nonzero phase fields with it off. This shows that each step shifts the clock by exactly one fast cycle and that the stabilizer gate works. Double-data-rate periods with overflowing and in-range samples check the order of the halves and when the flag is driven. Periods with mode and sample changes in mid-period show that only boundary values matter.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
  // log2 of the number of fast cycles in one sample period
  localparam int unsigned SLOT_W = 3;
  // width of the phase-select field; the invert bit supplies the top bit
  localparam int unsigned PH_W   = SLOT_W - 1;

  typedef struct packed {
    logic            twos;
    logic            ddr;
    logic            dcs;
    logic            inv;
    logic [PH_W-1:0] ph;
  } cfg_t;

  // Total clock delay in fast cycles: the invert bit is the half-period step.
  function automatic logic [SLOT_W-1:0] edge_offset(cfg_t c);
    logic [PH_W-1:0] p;
    p = c.dcs ? c.ph : '0;
    return {c.inv, p};
  endfunction
endpackage

// File: rtl/adcfmt_rst_sync.sv
module adcfmt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/adcfmt_slot_ctr.sv
module adcfmt_slot_ctr #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         bnd
);
  assign bnd     = (cnt_q == {W{1'b1}});
  assign cnt_nxt = cnt_q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/adcfmt_coder.sv
module adcfmt_coder #(
  parameter int unsigned IN_W = 14,
  parameter int unsigned DW   = 12
) (
  input  logic signed [IN_W-1:0] samp,
  input  logic                   twos,
  output logic [DW-1:0]          code,
  output logic                   over
);
  localparam int HI_I = (1 << (DW - 1)) - 1;
  localparam logic signed [IN_W-1:0] HI = IN_W'(HI_I);
  localparam logic signed [IN_W-1:0] LO = ~HI;

  logic          hi_clip;
  logic          lo_clip;
  logic [DW-1:0] tc;

  always_comb begin
    hi_clip = (samp > HI);
    lo_clip = (samp < LO);
    if (hi_clip)      tc = {1'b0, {(DW-1){1'b1}}};
    else if (lo_clip) tc = {1'b1, {(DW-1){1'b0}}};
    else              tc = samp[DW-1:0];
    // offset binary differs from two's complement only in the sign bit
    code = twos ? tc : {~tc[DW-1], tc[DW-2:0]};
    over = hi_clip | lo_clip;
  end
endmodule

// File: rtl/adcfmt_pipe.sv
module adcfmt_pipe #(
  parameter int unsigned W     = 13,
  parameter int unsigned DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_stg
    logic [W-1:0] st_q;
    logic [W-1:0] st_nxt;

    if (g == 0) begin : g_head
      assign st_nxt = en ? d : st_q;
    end else begin : g_body
      assign st_nxt = en ? g_stg[g-1].st_q : st_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_nxt;
    end
  end

  assign q = g_stg[DEPTH-1].st_q;
endmodule

// File: rtl/adcfmt_clkgen.sv
module adcfmt_clkgen #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] offs,
  output logic         clk_out
);
  logic [W-1:0] rel;
  logic         clk_d;

  // clock is high in the upper half of the count, counted from the shift
  assign rel   = cnt_nxt - offs;
  assign clk_d = rel[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_out <= 1'b0;
    else        clk_out <= clk_d;
  end
endmodule

// File: rtl/adcfmt_top.sv
module adcfmt_top
  import adcfmt_pkg::*;
#(
  parameter int unsigned IN_W     = 14,
  parameter int unsigned DW       = 12,
  parameter int unsigned PIPE_LAT = 5
) (
  input  logic                   clk_fast,
  input  logic                   rst_n,
  input  logic signed [IN_W-1:0] samp_in,
  input  logic                   fmt_twos,
  input  logic [PH_W-1:0]        ph_sel,
  input  logic                   clk_inv,
  input  logic                   dcs_en,
  input  logic                   ddr_en,
  output logic [DW-1:0]          dout,
  output logic                   ovf,
  output logic                   clk_out
);
  localparam int unsigned HALF   = DW / 2;
  localparam int unsigned WORD_W = DW + 1;
  localparam int unsigned MSB    = SLOT_W - 1;

  logic              rst_int_n;
  logic [SLOT_W-1:0] cnt_q;
  logic [SLOT_W-1:0] cnt_nxt;
  logic              bnd;
  cfg_t              cfg_in;
  cfg_t              cfg_nxt;
  cfg_t              cfg_q;
  logic [DW-1:0]     code_in;
  logic              over_in;
  logic [WORD_W-1:0] word_q;
  logic [DW-1:0]     data_q;
  logic              of_q;

  adcfmt_rst_sync u_rst (
    .clk        (clk_fast),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  adcfmt_slot_ctr #(.W(SLOT_W)) u_slot (
    .clk     (clk_fast),
    .rst_n   (rst_int_n),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .bnd     (bnd)
  );

  // mode inputs are taken only at the sample boundary
  assign cfg_in  = '{twos: fmt_twos, ddr: ddr_en, dcs: dcs_en, inv: clk_inv, ph: ph_sel};
  assign cfg_nxt = bnd ? cfg_in : cfg_q;

  always_ff @(posedge clk_fast or negedge rst_int_n) begin
    if (!rst_int_n) cfg_q <= '0;
    else            cfg_q <= cfg_nxt;
  end

  adcfmt_coder #(.IN_W(IN_W), .DW(DW)) u_coder (
    .samp (samp_in),
    .twos (cfg_in.twos),
    .code (code_in),
    .over (over_in)
  );

  // flag and data share one register chain so they cannot drift apart
  adcfmt_pipe #(.W(WORD_W), .DEPTH(PIPE_LAT)) u_pipe (
    .clk   (clk_fast),
    .rst_n (rst_int_n),
    .en    (bnd),
    .d     ({over_in, code_in}),
    .q     (word_q)
  );

  assign of_q   = word_q[DW];
  assign data_q = word_q[DW-1:0];

  adcfmt_clkgen #(.W(SLOT_W)) u_clk (
    .clk     (clk_fast),
    .rst_n   (rst_int_n),
    .cnt_nxt (cnt_nxt),
    .offs    (edge_offset(cfg_nxt)),
    .clk_out (clk_out)
  );

  always_comb begin
    if (cfg_q.ddr) begin
      dout           = '0;
      dout[HALF-1:0] = cnt_q[MSB] ? data_q[DW-1:HALF] : data_q[HALF-1:0];
      ovf            = cnt_q[MSB] & of_q;
    end else begin
      dout = data_q;
      ovf  = of_q;
    end
  end
endmodule

// File: rtl/adcfmt_chk.sv
module adcfmt_chk
  import adcfmt_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SLOT_W-1:0] cnt_q,
  input cfg_t              cfg_q,
  input logic [DW:0]       word_q,
  input logic [DW-1:0]     dout,
  input logic              ovf
);
  localparam int unsigned HALF = DW / 2;
  localparam int unsigned MSB  = SLOT_W - 1;

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != {SLOT_W{1'b1}}) |=> $stable(word_q));

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != {SLOT_W{1'b1}}) |=> $stable(cfg_q));

  // R6
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {SLOT_W{1'b1}}) |=> (cnt_q == '0));

  // R10
  ddr_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.ddr |-> (dout[DW-1:HALF] == '0));

  // R10
  ddr_low_half_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.ddr && !cnt_q[MSB]) |-> !ovf);

  // R2
  sat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.ddr && ovf) |-> ((&dout[DW-2:0]) || (~|dout[DW-2:0])));
endmodule

bind adcfmt_top adcfmt_chk #(.DW(DW)) u_chk (
  .clk    (clk_fast),
  .rst_n  (rst_int_n),
  .cnt_q  (cnt_q),
  .cfg_q  (cfg_q),
  .word_q (word_q),
  .dout   (dout),
  .ovf    (ovf)
);

// File: tb/test_adcfmt_top.sv
`timescale 1ns/1ps
module test_adcfmt_top;
  localparam int LAT = 5;

  typedef struct {
    int          tgt;
    logic [11:0] code;
    logic        of;
    logic        twos;
  } exp_t;

  logic               clk = 1'b0;
  logic               rst_n;
  logic signed [13:0] samp_in;
  logic               fmt_twos;
  logic [1:0]         ph_sel;
  logic               clk_inv;
  logic               dcs_en;
  logic               ddr_en;
  logic [11:0]        dout;
  logic               ovf;
  logic               clk_out;

  int   checks = 0;
  int   errors = 0;
  int   e      = 0;
  int   bidx   = 0;
  exp_t q[$];
  bit         h_inv  [0:255];
  bit         h_dcs  [0:255];
  bit         h_ddr  [0:255];
  bit         h_junk [0:255];
  bit [1:0]   h_ph   [0:255];

  always #2.5 clk = ~clk;

  adcfmt_top i_adcfmt_top (
    .clk_fast (clk),
    .rst_n    (rst_n),
    .samp_in  (samp_in),
    .fmt_twos (fmt_twos),
    .ph_sel   (ph_sel),
    .clk_inv  (clk_inv),
    .dcs_en   (dcs_en),
    .ddr_en   (ddr_en),
    .dout     (dout),
    .ovf      (ovf),
    .clk_out  (clk_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at edge %0d", tag, act, exp, e);
    end
  endtask

  // count rising edges since reset release and log the modes seen at each boundary
  always @(posedge clk) begin
    if (rst_n) begin
      e++;
      if (e >= 10 && (e - 2) % 8 == 0) begin
        bidx++;
        h_inv[bidx]  = clk_inv;
        h_dcs[bidx]  = dcs_en;
        h_ddr[bidx]  = ddr_en;
        h_ph[bidx]   = ph_sel;
        h_junk[bidx] = 1'b0;
      end
    end
  end

  // monitor: clock shape every cycle, scoreboard words at cycles 0, 4 and 7
  always @(negedge clk) begin
    int    c;
    int    eff;
    int    expclk;
    string tag;
    if (rst_n && e >= 2) begin
      c   = (e - 2) % 8;
      eff = (h_inv[bidx] ? 4 : 0) + (h_dcs[bidx] ? int'(h_ph[bidx]) : 0);
      expclk = ((((c - eff) % 8) + 8) % 8) >= 4 ? 1 : 0;
      if (bidx == 0)               tag = "R12 clk";
      else if (h_junk[bidx])       tag = "R11 clk";
      else if (h_inv[bidx])        tag = "R8 clk";
      else if (!h_dcs[bidx] && h_ph[bidx] != 0) tag = "R9 clk";
      else if (h_ph[bidx] != 0)    tag = "R7 clk";
      else                         tag = "R6 clk";
      chk(tag, int'(clk_out), expclk);

      if (q.size() > 0 && q[0].tgt < bidx) begin
        chk("R5 missing word", bidx, q[0].tgt);
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].tgt == bidx && (c == 0 || c == 4 || c == 7)) begin
        if (h_ddr[bidx]) begin
          if (c == 0) begin
            chk("R10 ddr low half", int'(dout), int'({6'b0, q[0].code[5:0]}));
            chk("R10 ddr flag low half", int'(ovf), 0);
          end else begin
            chk("R10 ddr high half", int'(dout), int'({6'b0, q[0].code[11:6]}));
            chk("R1 ddr flag", int'(ovf), int'(q[0].of));
          end
        end else begin
          if (c == 7)             tag = "R5 hold";
          else if (h_junk[bidx])  tag = "R11 data";
          else if (q[0].of)       tag = "R2 data";
          else if (q[0].twos)     tag = "R4 data";
          else                    tag = "R3 data";
          chk(tag, int'(dout), int'(q[0].code));
          chk("R1 flag", int'(ovf), int'(q[0].of));
        end
        if (c == 7) void'(q.pop_front());
      end
    end
  end

  // driver: set inputs just before a boundary and push the expected item
  task automatic send(input int v, input bit tw, input bit [1:0] ph, input bit inv,
                      input bit dcs, input bit ddr, input bit junk);
    exp_t it;
    int   t;
    do @(negedge clk); while (!(e >= 9 && (e - 1) % 8 == 0));
    samp_in  = 14'(v);
    fmt_twos = tw;
    ph_sel   = ph;
    clk_inv  = inv;
    dcs_en   = dcs;
    ddr_en   = ddr;
    if (v > 2047)       begin it.of = 1'b1; t = 2047;  end
    else if (v < -2048) begin it.of = 1'b0; it.of = 1'b1; t = -2048; end
    else                begin it.of = 1'b0; t = v;     end
    it.code = tw ? 12'(t) : 12'(t + 2048);
    it.twos = tw;
    it.tgt  = bidx + LAT;
    q.push_back(it);
    if (junk) begin
      repeat (3) @(negedge clk);
      h_junk[bidx] = 1'b1;
      samp_in  = 14'(v ^ 14'h1555);
      fmt_twos = ~tw;
      ph_sel   = ~ph;
      clk_inv  = ~inv;
      dcs_en   = ~dcs;
      ddr_en   = ~ddr;
    end
  endtask

  initial begin
    #500us;
    checks++;
    errors++;
    $display("FAIL R5 watchdog: actual pending %0d expected 0", q.size());
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    rst_n    = 1'b0;
    samp_in  = '0;
    fmt_twos = 1'b0;
    ph_sel   = 2'd0;
    clk_inv  = 1'b0;
    dcs_en   = 1'b0;
    ddr_en   = 1'b0;
    h_inv[0] = 1'b0; h_dcs[0] = 1'b0; h_ddr[0] = 1'b0; h_ph[0] = 2'd0; h_junk[0] = 1'b0;
    repeat (4) @(negedge clk);
    // R12: reset state at the ports
    chk("R12 reset dout", int'(dout), 0);
    chk("R12 reset ovf", int'(ovf), 0);
    chk("R12 reset clk", int'(clk_out), 0);
    rst_n = 1'b1;

    // R3 and R2 in offset binary around both clip points
    send(0, 0, 0, 0, 1, 0, 0);
    send(-1, 0, 0, 0, 1, 0, 0);
    send(2047, 0, 0, 0, 1, 0, 0);
    send(2048, 0, 0, 0, 1, 0, 0);
    send(-2048, 0, 0, 0, 1, 0, 0);
    send(-2049, 0, 0, 0, 1, 0, 0);
    send(8191, 0, 0, 0, 1, 0, 0);
    send(-8192, 0, 0, 0, 1, 0, 0);
    // R4 and R2 in two's complement
    send(0, 1, 0, 0, 1, 0, 0);
    send(-1, 1, 0, 0, 1, 0, 0);
    send(2047, 1, 0, 0, 1, 0, 0);
    send(2048, 1, 0, 0, 1, 0, 0);
    send(-2048, 1, 0, 0, 1, 0, 0);
    send(-2049, 1, 0, 0, 1, 0, 0);
    // R7 and R8: all eight shifts with the stabilizer on
    for (int k = 0; k < 8; k++) send(100 * k - 300, k % 2, 2'(k), k >= 4, 1, 0, 0);
    // R9: phase field ignored with the stabilizer off
    send(321, 0, 3, 0, 0, 0, 0);
    send(-321, 1, 2, 1, 0, 0, 0);
    send(55, 0, 1, 0, 0, 0, 0);
    // R10: double data rate with in-range and clipped samples
    send(1234, 0, 0, 0, 1, 1, 0);
    send(-3000, 1, 1, 0, 1, 1, 0);
    send(4000, 0, 2, 1, 1, 1, 0);
    send(-77, 1, 0, 0, 1, 1, 0);
    // R11: inputs disturbed in mid-period
    send(600, 0, 1, 0, 1, 0, 1);
    send(-2500, 1, 2, 1, 1, 1, 1);
    send(-900, 1, 3, 0, 0, 0, 1);
    send(0, 0, 0, 0, 1, 0, 0);
    // mixed pseudo-random traffic
    seed = 13;
    for (int k = 0; k < 16; k++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      send(((seed >> 4) % 16384) - 8192, seed[1], 2'(seed >> 2), seed[5], seed[6], seed[7], seed[8]);
    end
    while (q.size() > 0) @(negedge clk);
    repeat (8) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule